// File: doc/BRIEF.md
# Chainable Interval Timer

The block is a periodic timer on a small register bus. Software sets a modulo value and a prescale select, then enables the timer. A divided clock tick advances a counter from 1 up to the modulo value. On the tick that reaches the modulo the counter returns to 1 and a sticky rollover flag is set. Software clears the flag by writing one to it. When interrupts are enabled, the flag drives an interrupt line.

Each timer drives a strobe, `sync_out`, that is high on every cycle in which the timer advances. A timer in slave mode ignores its own prescaler and advances only on cycles where `sync_in` is high. Wiring one timer's `sync_out` to the `sync_in` of others therefore chains them onto a common time base.

Two parameters select the build. `DATA_W` picks a 16-bit or an 8-bit bus; on the 8-bit bus each 16-bit register is split into a low byte and a high byte at consecutive addresses. `PRESCALE_EN` can remove the prescaler.

Two state machines run the block. The bus machine has two states. It goes from `BUS_IDLE` to `BUS_RESP` when the strobe is sampled, carrying out the access on that edge, and always returns from `BUS_RESP` to `BUS_IDLE`. The mode machine is `TMR_STOP`, `TMR_MASTER` or `TMR_SLAVE`, and it follows the enable and slave bits one cycle after they are written. It enters `TMR_STOP` whenever the enable bit is 0. With the enable bit at 1, it enters `TMR_SLAVE` if the slave bit is 1 and `TMR_MASTER` if it is 0.

Top module: `chain_timer`

## Requirements
- R1: With the 16-bit bus, after reset, word 0 (control) reads 0x4000, word 1 (modulo) reads 0x0000 and word 2 (counter) reads 0x0001.
- R2: Control word layout: bit 0 enable, bit 1 interrupt enable, bit 2 rollover flag, bits 11:8 prescale select, bit 15 slave mode. Bit 14 is read-only and reads 1. All other bits read 0. Writing 0xFFFE reads back 0xCF02, and writing 0x0000 reads back 0x4000.
- R3: The modulo word stores any 16-bit value; 0x5555 and 0xAAAA read back unchanged.
- R4: The counter word ignores writes; after a write of 0xFFFE to a stopped timer at reset it still reads 0x0001.
- R5: In master mode with prescale select N, the timer advances once every 2^N clocks, and `sync_out` is high on exactly those cycles.
- R6: On an advance where the counter equals the modulo, the counter reloads to 1 and the flag is set, so flags recur every modulo advances. A modulo of 0 gives 65536 advances.
- R7: The flag stays set until a control write with bit 2 = 1. A control write with bit 2 = 0 leaves it set.
- R8: `irq` is high exactly when both the flag and the interrupt enable are set.
- R9: With the enable bit cleared, the counter holds its value and the modulo is kept.
- R10: In slave mode the timer advances only on cycles with `sync_in` high, whatever its prescale select, and `sync_out` follows those advances.
- R11: With the 8-bit bus, byte addresses 0..5 hold control low and high, modulo low and high, and counter low and high. After reset they read 00, 40, 00, 00, 01, 00. Writing 0xFE to address 0 reads back 0x02. The counter bytes ignore writes.
- R12: With the prescaler removed, a master timer advances on every clock whatever the prescale select.
- R13: `bus_ack` rises one cycle after the strobe is sampled, lasts one cycle, and `bus_rdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stb | input | 1 | Access strobe, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (16-bit bus) or byte address (8-bit bus) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle access acknowledge |
| sync_in | input | 1 | Count enable used in slave mode |
| sync_out | output | 1 | High on each cycle the timer advances |
| irq | output | 1 | Interrupt, flag AND interrupt enable |

## Verification
The bench builds two instances. The first uses the 16-bit bus with the prescaler; it covers the register layout, the prescale periods, the 65536-step wrap and slave advance under pulses driven directly by the bench. The second uses the 8-bit bus without a prescaler, and its `sync_in` comes from the first timer's `sync_out`. That brings the byte address map, a real two-timer chain and the every-clock variant within reach. Periods are measured as the cycle distance between successive interrupt rises, so the result does not depend on the start-up latency of the mode machine.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_W    = 16;
    localparam int PS_SEL_W = 4;

    // control word bit positions (software visible)
    localparam int B_EN    = 0;
    localparam int B_IEN   = 1;
    localparam int B_FLAG  = 2;
    localparam int B_PS_LO = 8;
    localparam int B_ID    = 14;
    localparam int B_SLAVE = 15;

    typedef enum logic [1:0] {
        TMR_STOP   = 2'd0,
        TMR_MASTER = 2'd1,
        TMR_SLAVE  = 2'd2
    } tmr_mode_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic                slave;
        logic [PS_SEL_W-1:0] ps_sel;
        logic                ien;
        logic                en;
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter bit PRESCALE_EN = 1'b1,
    parameter int SEL_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (!run_i) div_q <= '0;
        else             div_q <= div_q + DIV_W'(1);
    end

    generate
        if (PRESCALE_EN) begin : g_scaled
            assign mask = (DIV_W'(1) << sel_i) - DIV_W'(1);

            // R5
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_o && sel_i != '0) |=> (!tick_o || sel_i != $past(sel_i)));
        end else begin : g_bypass
            logic unused_sel;
            assign unused_sel = ^sel_i;
            assign mask = '0;
        end
    endgenerate

    assign tick_o = run_i && ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             slave_i,
    input  logic             ps_tick_i,
    input  logic             ext_i,
    input  logic [CNT_W-1:0] modulo_i,
    output logic             run_o,
    output logic             adv_o,
    output logic             roll_o,
    output logic [CNT_W-1:0] cnt_o
);
    tmr_mode_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_STOP:   if (en_i)     state_d = slave_i ? TMR_SLAVE : TMR_MASTER;
            TMR_MASTER: if (!en_i)    state_d = TMR_STOP;
                        else if (slave_i) state_d = TMR_SLAVE;
            TMR_SLAVE:  if (!en_i)    state_d = TMR_STOP;
                        else if (!slave_i) state_d = TMR_MASTER;
            default:    state_d = TMR_STOP;
        endcase
    end

    // outputs
    always_comb begin
        run_o = 1'b0;
        adv_o = 1'b0;
        unique case (state_q)
            TMR_MASTER: begin run_o = 1'b1; adv_o = ps_tick_i; end
            TMR_SLAVE:  adv_o = ext_i;
            default:    ;
        endcase
    end

    assign roll_o = adv_o && (cnt_q == modulo_i);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= CNT_W'(1);
        else if (roll_o) cnt_q <= CNT_W'(1);
        else if (adv_o)  cnt_q <= cnt_q + CNT_W'(1);
    end

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_o |=> $stable(cnt_q));

    // R10
    slave_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_SLAVE && !ext_i) |-> !adv_o);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ack_o,
    input  logic              roll_i,
    input  logic [REG_W-1:0]  cnt_i,
    output tmr_cfg_t          cfg_o,
    output logic [REG_W-1:0]  modulo_o,
    output logic              flag_o,
    output logic              irq_o
);
    bus_state_e        state_q, state_d;
    logic [1:0]        word;
    logic              lane_lo, lane_hi;
    logic [REG_W-1:0]  wd16;
    logic [REG_W-1:0]  word_rd;
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] rd_q;
    logic              access, wr_en, rd_en;
    logic              ctrl_lo_wr, ctrl_hi_wr, mod_lo_wr, mod_hi_wr, flag_clr;
    tmr_cfg_t          cfg_q;
    logic [REG_W-1:0]  mod_q;
    logic              flag_q;

    assign word = addr_i[ADDR_W-1 -: 2];

    generate
        if (DATA_W == REG_W) begin : g_wide
            assign lane_lo = 1'b1;
            assign lane_hi = 1'b1;
            assign wd16    = wdata_i;
            assign rd_sel  = word_rd;
        end else begin : g_narrow
            assign lane_lo = ~addr_i[0];
            assign lane_hi = addr_i[0];
            assign wd16    = {wdata_i, wdata_i};
            assign rd_sel  = addr_i[0] ? word_rd[15:8] : word_rd[7:0];
        end
    endgenerate

    // bus state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (stb_i) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        ack_o  = 1'b0;
        access = 1'b0;
        unique case (state_q)
            BUS_IDLE: access = stb_i;
            BUS_RESP: ack_o  = 1'b1;
            default:  ;
        endcase
    end

    assign wr_en      = access && we_i;
    assign rd_en      = access && !we_i;
    assign ctrl_lo_wr = wr_en && word == 2'd0 && lane_lo;
    assign ctrl_hi_wr = wr_en && word == 2'd0 && lane_hi;
    assign mod_lo_wr  = wr_en && word == 2'd1 && lane_lo;
    assign mod_hi_wr  = wr_en && word == 2'd1 && lane_hi;
    assign flag_clr   = ctrl_lo_wr && wd16[B_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            mod_q <= '0;
        end else begin
            if (ctrl_lo_wr) begin
                cfg_q.en  <= wd16[B_EN];
                cfg_q.ien <= wd16[B_IEN];
            end
            if (ctrl_hi_wr) begin
                cfg_q.slave  <= wd16[B_SLAVE];
                cfg_q.ps_sel <= wd16[B_PS_LO +: PS_SEL_W];
            end
            if (mod_lo_wr) mod_q[7:0]  <= wd16[7:0];
            if (mod_hi_wr) mod_q[15:8] <= wd16[15:8];
        end
    end

    // rollover takes priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (roll_i)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    always_comb begin
        word_rd = '0;
        unique case (word)
            2'd0: begin
                word_rd[B_SLAVE]                = cfg_q.slave;
                word_rd[B_ID]                   = 1'b1;
                word_rd[B_PS_LO +: PS_SEL_W]    = cfg_q.ps_sel;
                word_rd[B_FLAG]                 = flag_q;
                word_rd[B_IEN]                  = cfg_q.ien;
                word_rd[B_EN]                   = cfg_q.en;
            end
            2'd1:    word_rd = mod_q;
            2'd2:    word_rd = cnt_i;
            default: word_rd = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_sel;
    end

    assign rdata_o  = rd_q;
    assign cfg_o    = cfg_q;
    assign modulo_o = mod_q;
    assign flag_o   = flag_q;
    assign irq_o    = flag_q && cfg_q.ien;

    // R13
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/chain_timer.sv
module chain_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter bit PRESCALE_EN = 1'b1,
    parameter int ADDR_W      = (DATA_W == 16) ? 2 : 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              irq
);
    tmr_cfg_t         cfg;
    logic [REG_W-1:0] modulo;
    logic [REG_W-1:0] cnt;
    logic             flag, roll, run, ps_tick, adv;

    tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .stb_i(bus_stb), .we_i(bus_we),
        .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .ack_o(bus_ack), .roll_i(roll), .cnt_i(cnt), .cfg_o(cfg),
        .modulo_o(modulo), .flag_o(flag), .irq_o(irq)
    );

    tmr_prescale #(.PRESCALE_EN(PRESCALE_EN), .SEL_W(PS_SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .sel_i(cfg.ps_sel), .tick_o(ps_tick)
    );

    tmr_count #(.CNT_W(REG_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(cfg.en), .slave_i(cfg.slave),
        .ps_tick_i(ps_tick), .ext_i(sync_in), .modulo_i(modulo),
        .run_o(run), .adv_o(adv), .roll_o(roll), .cnt_o(cnt)
    );

    assign sync_out = adv;

    // R6
    reload_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> cnt == REG_W'(1));
endmodule

// File: tb/chain_timer_tb_top.sv
module chain_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // instance A: 16-bit bus with prescaler
    logic        a_stb = 1'b0, a_we = 1'b0;
    logic [1:0]  a_addr = '0;
    logic [15:0] a_wd = '0, a_rd;
    logic        a_ack, a_irq, a_sync;
    logic        ext = 1'b0;
    // instance B: 8-bit bus, no prescaler, chained
    logic        b_stb = 1'b0, b_we = 1'b0;
    logic [2:0]  b_addr = '0;
    logic [7:0]  b_wd = '0, b_rd;
    logic        b_ack, b_irq, b_sync;

    chain_timer #(.DATA_W(16), .PRESCALE_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_stb(a_stb), .bus_we(a_we),
        .bus_addr(a_addr), .bus_wdata(a_wd), .bus_rdata(a_rd), .bus_ack(a_ack),
        .sync_in(ext), .sync_out(a_sync), .irq(a_irq)
    );

    chain_timer #(.DATA_W(8), .PRESCALE_EN(1'b0)) dut8_i (
        .clk(clk), .rst_n(rst_n), .bus_stb(b_stb), .bus_we(b_we),
        .bus_addr(b_addr), .bus_wdata(b_wd), .bus_rdata(b_rd), .bus_ack(b_ack),
        .sync_in(a_sync), .sync_out(b_sync), .irq(b_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int inst, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        if (inst == 0) begin a_stb = 1; a_we = 1; a_addr = a[1:0]; a_wd = d; end
        else           begin b_stb = 1; b_we = 1; b_addr = a;      b_wd = d[7:0]; end
        do @(negedge clk); while (!((inst == 0) ? a_ack : b_ack));
        if (inst == 0) a_stb = 0; else b_stb = 0;
    endtask

    task automatic bus_rd(input int inst, input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        if (inst == 0) begin a_stb = 1; a_we = 0; a_addr = a[1:0]; end
        else           begin b_stb = 1; b_we = 0; b_addr = a; end
        do @(negedge clk); while (!((inst == 0) ? a_ack : b_ack));
        d = (inst == 0) ? a_rd : {8'h00, b_rd};
        if (inst == 0) a_stb = 0; else b_stb = 0;
    endtask

    task automatic wait_irq(input int inst, output int t);
        do @(negedge clk); while (!((inst == 0) ? a_irq : b_irq));
        t = cyc;
    endtask

    // irq period: wait one rise, clear with cfg|flag, wait next rise
    task automatic irq_period(input int inst, input logic [15:0] cfg, output int p);
        int t0, t1;
        wait_irq(inst, t0);
        bus_wr(inst, 3'd0, cfg | 16'h0004);
        wait_irq(inst, t1);
        p = t1 - t0;
    endtask

    task automatic sync_period(output int p);
        int t0;
        do @(negedge clk); while (!a_sync);
        t0 = cyc;
        do @(negedge clk); while (!a_sync);
        p = cyc - t0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        bus_rd(0, 3'd0, v); chk("R1 ctrl reset", v, 16'h4000);
        bus_rd(0, 3'd1, v); chk("R1 mod reset", v, 16'h0000);
        bus_rd(0, 3'd2, v); chk("R1 count reset", v, 16'h0001);
        chk("R8 irq low at reset", a_irq, 0);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        a_stb = 1; a_we = 0; a_addr = 2'd0;
        #0 chk("R13 no ack before edge", a_ack, 0);
        @(negedge clk);
        chk("R13 ack after one edge", a_ack, 1);
        chk("R13 rdata with ack", a_rd, 16'h4000);
        a_stb = 0;
        @(negedge clk);
        chk("R13 ack one cycle", a_ack, 0);
    endtask

    task automatic t_regs16;
        logic [15:0] v;
        bus_wr(0, 3'd0, 16'hFFFE); bus_rd(0, 3'd0, v); chk("R2 ctrl 0xFFFE", v, 16'hCF02);
        bus_wr(0, 3'd0, 16'h0000); bus_rd(0, 3'd0, v); chk("R2 ctrl 0x0000", v, 16'h4000);
        bus_wr(0, 3'd1, 16'h5555); bus_rd(0, 3'd1, v); chk("R3 mod 5555", v, 16'h5555);
        bus_wr(0, 3'd1, 16'hAAAA); bus_rd(0, 3'd1, v); chk("R3 mod AAAA", v, 16'hAAAA);
        bus_wr(0, 3'd2, 16'hFFFE); bus_rd(0, 3'd2, v); chk("R4 count read-only", v, 16'h0001);
    endtask

    task automatic t_regs8;
        logic [15:0] v;
        logic [7:0] rst_exp [6] = '{8'h00, 8'h40, 8'h00, 8'h00, 8'h01, 8'h00};
        for (int i = 0; i < 6; i++) begin
            bus_rd(1, 3'(i), v); chk("R11 byte reset", v, {8'h00, rst_exp[i]});
        end
        bus_wr(1, 3'd0, 16'h00FE); bus_rd(1, 3'd0, v); chk("R11 ctrl lo 0xFE", v, 16'h0002);
        bus_rd(1, 3'd1, v); chk("R11 ctrl hi kept", v, 16'h0040);
        bus_wr(1, 3'd0, 16'h0000);
        bus_wr(1, 3'd2, 16'h0055); bus_wr(1, 3'd3, 16'h0099);
        bus_rd(1, 3'd2, v); chk("R11 mod lo", v, 16'h0055);
        bus_rd(1, 3'd3, v); chk("R11 mod hi", v, 16'h0099);
        bus_wr(1, 3'd4, 16'h00FE); bus_wr(1, 3'd5, 16'h00FE);
        bus_rd(1, 3'd4, v); chk("R11 count lo read-only", v, 16'h0001);
        bus_rd(1, 3'd5, v); chk("R11 count hi read-only", v, 16'h0000);
    endtask

    task automatic t_prescale;
        int p;
        bus_wr(0, 3'd0, 16'h0000);
        bus_wr(0, 3'd1, 16'd3);
        bus_wr(0, 3'd0, 16'h0207);              // ps=2, ien, en
        sync_period(p); chk("R5 ps2 sync spacing", p, 4);
        irq_period(0, 16'h0203, p); chk("R6 ps2 mod3 period", p, 12);
        bus_wr(0, 3'd0, 16'h0000);
        bus_wr(0, 3'd1, 16'd5);
        bus_wr(0, 3'd0, 16'h0007);              // ps=0
        sync_period(p); chk("R5 ps0 sync every clock", p, 1);
        irq_period(0, 16'h0003, p); chk("R6 ps0 mod5 period", p, 5);
    endtask

    task automatic t_flag;
        logic [15:0] v, c1, c2;
        int t;
        wait_irq(0, t);
        chk("R8 irq with flag and ien", a_irq, 1);
        bus_wr(0, 3'd0, 16'h0000);              // stop, flag written 0
        bus_rd(0, 3'd0, v); chk("R7 flag kept after write 0", v & 16'h0004, 16'h0004);
        chk("R8 irq low with ien clear", a_irq, 0);
        repeat (20) @(negedge clk);
        bus_rd(0, 3'd0, v); chk("R7 flag sticky", v & 16'h0004, 16'h0004);
        bus_rd(0, 3'd2, c1);
        repeat (30) @(negedge clk);
        bus_rd(0, 3'd2, c2); chk("R9 count held when disabled", c2, c1);
        bus_rd(0, 3'd1, v); chk("R9 modulo kept", v, 16'd5);
        bus_wr(0, 3'd0, 16'h0004);
        bus_rd(0, 3'd0, v); chk("R7 flag cleared by write 1", v, 16'h4000);
    endtask

    task automatic t_wrap;
        int t0, t1;
        bus_wr(0, 3'd1, 16'd4);
        bus_wr(0, 3'd0, 16'h0007);
        wait_irq(0, t0);
        bus_wr(0, 3'd1, 16'd0);
        bus_wr(0, 3'd0, 16'h0007);
        wait_irq(0, t1);
        chk("R6 modulo 0 gives 65536", t1 - t0, 65536);
        bus_wr(0, 3'd0, 16'h0004);
    endtask

    task automatic pulse_ext;
        @(negedge clk); ext = 1;
        #1 chk("R10 sync_out follows sync_in", a_sync, 1);
        @(negedge clk); ext = 0;
    endtask

    task automatic t_slave;
        logic [15:0] c0, v;
        bus_wr(0, 3'd0, 16'h0004);
        bus_rd(0, 3'd2, c0);
        bus_wr(0, 3'd1, c0 + 16'd2);
        bus_wr(0, 3'd0, 16'h8F07);              // slave, ps=15, ien, en
        repeat (20) @(negedge clk);
        bus_rd(0, 3'd2, v); chk("R10 no advance without sync_in", v, c0);
        pulse_ext; pulse_ext;
        repeat (3) @(negedge clk);
        bus_rd(0, 3'd2, v); chk("R10 two pulses two steps", v, c0 + 16'd2);
        chk("R10 no flag yet", a_irq, 0);
        pulse_ext;
        @(negedge clk);
        chk("R10 flag on third pulse", a_irq, 1);
        bus_rd(0, 3'd2, v); chk("R6 reload to 1", v, 16'h0001);
        bus_wr(0, 3'd0, 16'h0004);
    endtask

    task automatic t_chain;
        int p;
        bus_wr(0, 3'd1, 16'hFFFF);
        bus_wr(0, 3'd0, 16'h0101);              // master ps=1, every 2 clocks
        bus_wr(1, 3'd2, 16'h0003); bus_wr(1, 3'd3, 16'h0000);
        bus_wr(1, 3'd1, 16'h0080);              // slave
        bus_wr(1, 3'd0, 16'h0007);
        irq_period(1, 16'h0003, p); chk("R10 chained slave period", p, 6);
        bus_wr(1, 3'd0, 16'h0000);
        bus_wr(1, 3'd1, 16'h000F);              // master, ps select 15
        bus_wr(1, 3'd0, 16'h0007);
        irq_period(1, 16'h0003, p); chk("R12 no prescaler every clock", p, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_handshake;
        t_regs16;
        t_regs8;
        t_prescale;
        t_flag;
        t_wrap;
        t_slave;
        t_chain;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule